// File: doc/BRIEF.md
# Conversion Result Accumulator and Monitor

This block post-processes the stream of signed 16-bit results that a sigma-delta conversion path delivers, one result per valid strobe. It drops the results that arrive while the decimation filter is still settling. Each settled result goes out again one cycle later. The block can also add each settled result into a 32-bit running sum, count settled results against a programmed period, and compare each settled result's magnitude against a threshold. Separately, it watches every raw result, settled or not, for a full-scale code.

Software programs the block through a small register port, which uses a write strobe, an address, write data and a combinational read-data bus. Events are held in sticky status flags, and software clears them by writing a one to the flag's bit. The count, threshold and overrange flags also drive three interrupt outputs directly. A restart pulse marks the start of a new conversion sequence and re-arms the settling filter.

Top module: `adc_accum_mon`

## Requirements
- R1: After reset, the control, limit, threshold, status, accumulator and count registers all read 0. The outputs `out_valid`, `irq_count`, `irq_thresh` and `irq_ovr` are all 0.
- R2: Reset and a `restart` pulse each re-arm settling. After re-arming, the first two valid results are discarded when the chop bit (control bit 4) is 0, and the first one is discarded when it is 1. A result that arrives in the same cycle as `restart` is ignored and does not count toward settling.
- R3: A settled result appears on `out_data` with `out_valid` high exactly one cycle after its strobe. A discarded result produces no `out_valid`.
- R4: While control bit 0 is 1, each settled result is sign-extended to 32 bits and added to the accumulator. The accumulator reads at address 5.
- R5: The accumulator wraps modulo 2^32. A signed overflow on an add sets the sticky status bit 3.
- R6: While control bit 1 is 1, each settled result increments the counter, which reads at address 6. When the counter would reach the limit held at address 1, status bit 0 is set and the counter reloads to 0. A limit of 0 never fires.
- R7: While control bit 2 is 1, a settled result whose magnitude is strictly greater than the unsigned threshold at address 2 sets the sticky status bit 1. A magnitude equal to the threshold does not set it.
- R8: While control bit 3 is 1, any valid raw result equal to 16'h7FFF or 16'h8000 sets the sticky status bit 2. This applies even when the result is being discarded for settling.
- R9: Writing 1 to bit 0 at address 3 zeroes the accumulator and the counter in that cycle. A settled result arriving in the same cycle becomes the first new term of both.
- R10: Status reads at address 4. Writing a 1 to a status bit clears it, but a new event in the same cycle wins over the clear. The outputs `irq_count`, `irq_thresh` and `irq_ovr` follow status bits 0, 1 and 2.
- R11: When a function's enable bit is 0, results have no effect on that function's register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 16 | Signed conversion result |
| restart | input | 1 | Start of a new conversion sequence |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| out_valid | output | 1 | Settled result valid |
| out_data | output | 16 | Settled result |
| irq_count | output | 1 | Count period reached |
| irq_thresh | output | 1 | Threshold exceeded |
| irq_ovr | output | 1 | Full-scale code seen |

## Verification
Three patterns exercise settling: a mixed-sign sequence with chop off, a sequence right after a restart with chop on, and a restart in the same cycle as a result. Together they separate the two- and one-result discard depths and show whether the restart-cycle result is counted. Threshold stimulus uses a result exactly equal to the threshold and a negative result one step beyond it. This separates a strict comparison from a non-strict one, and a magnitude comparison from a signed one. A long burst of near-full-scale results is checked one add before and one add after the signed limit, which pins where the overflow flag first sets. A clear written in the same cycle as a result shows whether that result is kept or lost.

// File: rtl/adcm_pkg.sv
package adcm_pkg;

    localparam int RES_W  = 16;
    localparam int ACC_W  = 32;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;
    localparam int REG_W  = 32;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_LIMIT  = 3'd1,
        A_THRESH = 3'd2,
        A_CLEAR  = 3'd3,
        A_STATUS = 3'd4,
        A_ACC    = 3'd5,
        A_COUNT  = 3'd6
    } reg_addr_e;

    // bit 4 chop, bit 3 overrange enable, bit 2 threshold enable,
    // bit 1 count enable, bit 0 accumulate enable
    typedef struct packed {
        logic chop;
        logic ovr_en;
        logic thr_en;
        logic cnt_en;
        logic acc_en;
    } ctrl_t;

    // bit 3 accumulator overflow, bit 2 overrange, bit 1 threshold, bit 0 count
    typedef struct packed {
        logic acc_ovf;
        logic ovr;
        logic thr;
        logic cnt;
    } status_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = $bits(status_t);

    // number of leading results that the filter leaves unsettled
    function automatic logic [1:0] settle_discards(input logic chop);
        return chop ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/adcm_settle.sv
module adcm_settle
    import adcm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic in_valid,
    input  logic chop,
    output logic settled
);
    logic [1:0] seen_q;
    logic       ready;

    assign ready   = (seen_q >= settle_discards(chop));
    assign settled = in_valid && !restart && ready;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            seen_q <= '0;
        end else if (in_valid && !ready) begin
            seen_q <= seen_q + 2'd1;
        end
    end
endmodule

// File: rtl/adcm_accum.sv
module adcm_accum #(
    parameter int RES_W = 16,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             add_en,
    input  logic [RES_W-1:0] res,
    output logic [ACC_W-1:0] acc,
    output logic             ovf
);
    localparam int EXT_W = ACC_W - RES_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] term;
    logic [ACC_W-1:0] sum;

    assign base = clear ? '0 : acc_q;
    assign term = {{EXT_W{res[RES_W-1]}}, res};
    assign sum  = base + term;
    assign ovf  = add_en && (base[ACC_W-1] == term[ACC_W-1])
                         && (sum[ACC_W-1] != base[ACC_W-1]);
    assign acc  = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= add_en ? sum : base;
        end
    end
endmodule

// File: rtl/adcm_counter.sv
module adcm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   nxt;

    assign base  = clear ? '0 : cnt_q;
    assign nxt   = {1'b0, base} + 1'b1;
    assign hit   = tick && (nxt == {1'b0, limit});
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= hit ? '0 : nxt[CNT_W-1:0];
        end else begin
            cnt_q <= base;
        end
    end
endmodule

// File: rtl/adcm_monitor.sv
module adcm_monitor #(
    parameter int RES_W = 16
) (
    input  logic [RES_W-1:0] res,
    input  logic [RES_W-1:0] thresh,
    output logic             over_thr,
    output logic             full_scale
);
    localparam logic [RES_W-1:0] POS_FS = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] NEG_FS = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W:0] wide;
    logic [RES_W:0] mag;

    assign wide       = {res[RES_W-1], res};
    assign mag        = res[RES_W-1] ? (~wide + 1'b1) : wide;
    assign over_thr   = mag > {1'b0, thresh};
    assign full_scale = (res == POS_FS) || (res == NEG_FS);
endmodule

// File: rtl/adc_accum_mon.sv
module adc_accum_mon
    import adcm_pkg::*;
#(
    parameter int DATA_W = adcm_pkg::RES_W,
    parameter int SUM_W  = adcm_pkg::ACC_W,
    parameter int PER_W  = adcm_pkg::CNT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     res_valid,
    input  logic [DATA_W-1:0]        res_data,
    input  logic                     restart,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_data,
    output logic                     irq_count,
    output logic                     irq_thresh,
    output logic                     irq_ovr
);
    ctrl_t             ctrl_q;
    status_t           status_q;
    status_t           status_set;
    status_t           status_w1c;
    logic [PER_W-1:0]  limit_q;
    logic [DATA_W-1:0] thresh_q;
    logic              out_valid_q;
    logic [DATA_W-1:0] out_data_q;

    logic              settled;
    logic              clear_hit;
    logic [SUM_W-1:0]  acc_val;
    logic              acc_ovf;
    logic [PER_W-1:0]  cnt_val;
    logic              cnt_hit;
    logic              over_thr;
    logic              full_scale;
    reg_addr_e         addr_e;

    assign addr_e    = reg_addr_e'(reg_addr);
    assign clear_hit = reg_wr && (addr_e == A_CLEAR) && reg_wdata[0];

    adcm_settle u_settle (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .in_valid (res_valid),
        .chop     (ctrl_q.chop),
        .settled  (settled)
    );

    adcm_accum #(.RES_W(DATA_W), .ACC_W(SUM_W)) u_accum (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear_hit),
        .add_en (settled && ctrl_q.acc_en),
        .res    (res_data),
        .acc    (acc_val),
        .ovf    (acc_ovf)
    );

    adcm_counter #(.CNT_W(PER_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .clear (clear_hit),
        .tick  (settled && ctrl_q.cnt_en),
        .limit (limit_q),
        .count (cnt_val),
        .hit   (cnt_hit)
    );

    adcm_monitor #(.RES_W(DATA_W)) u_mon (
        .res        (res_data),
        .thresh     (thresh_q),
        .over_thr   (over_thr),
        .full_scale (full_scale)
    );

    always_comb begin
        status_set.acc_ovf = acc_ovf;
        status_set.ovr     = res_valid && ctrl_q.ovr_en && full_scale;
        status_set.thr     = settled && ctrl_q.thr_en && over_thr;
        status_set.cnt     = cnt_hit;
        status_w1c         = (reg_wr && (addr_e == A_STATUS))
                             ? status_t'(reg_wdata[STAT_W-1:0]) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            limit_q     <= '0;
            thresh_q    <= '0;
            status_q    <= '0;
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
        end else begin
            status_q    <= (status_q & ~status_w1c) | status_set;
            out_valid_q <= settled;
            if (settled) begin
                out_data_q <= res_data;
            end
            if (reg_wr) begin
                case (addr_e)
                    A_CTRL:   ctrl_q   <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
                    A_LIMIT:  limit_q  <= reg_wdata[PER_W-1:0];
                    A_THRESH: thresh_q <= reg_wdata[DATA_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (addr_e)
            A_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_q;
            A_LIMIT:  reg_rdata[PER_W-1:0]  = limit_q;
            A_THRESH: reg_rdata[DATA_W-1:0] = thresh_q;
            A_STATUS: reg_rdata[STAT_W-1:0] = status_q;
            A_ACC:    reg_rdata[SUM_W-1:0]  = acc_val;
            A_COUNT:  reg_rdata[PER_W-1:0]  = cnt_val;
            default:  reg_rdata = '0;
        endcase
    end

    assign out_valid  = out_valid_q;
    assign out_data   = out_data_q;
    assign irq_count  = status_q.cnt;
    assign irq_thresh = status_q.thr;
    assign irq_ovr    = status_q.ovr;
endmodule

// File: rtl/adcm_checker.sv
module adcm_checker #(
    parameter int DATA_W = 16,
    parameter int PER_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              restart,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              out_valid,
    input logic              irq_thresh,
    input logic              irq_ovr,
    input logic              ovf_flag,
    input logic              ovr_en,
    input logic [PER_W-1:0]  count_val
);
    localparam logic [DATA_W-1:0] POS_FS = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

    logic st_wr;
    assign st_wr = reg_wr && (reg_addr == 3'd4);

    // R3: an output only ever follows a strobe that was not a restart cycle
    assert_out_follows_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(res_valid) && !$past(restart)));

    // R2: the result of a restart cycle is never passed on
    assert_restart_result_dropped_R2: assert property (@(posedge clk) disable iff (rst)
        (res_valid && restart) |=> !out_valid);

    // R7: threshold flag is held until software clears it
    assert_thr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_thresh && !(st_wr && reg_wdata[1])) |=> irq_thresh);

    // R8: an enabled full-scale code raises the overrange flag
    assert_ovr_detect_R8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && ovr_en && (res_data == POS_FS || res_data == NEG_FS)) |=> irq_ovr);

    // R5: overflow flag is held until software clears it
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !(st_wr && reg_wdata[3])) |=> ovf_flag);

    // R9: a clear leaves at most the one new term in the counter
    assert_clear_count_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd3 && reg_wdata[0]) |=> (count_val <= 1));
endmodule

bind adc_accum_mon adcm_checker #(.DATA_W(DATA_W), .PER_W(PER_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .restart    (restart),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .out_valid  (out_valid),
    .irq_thresh (irq_thresh),
    .irq_ovr    (irq_ovr),
    .ovf_flag   (status_q.acc_ovf),
    .ovr_en     (ctrl_q.ovr_en),
    .count_val  (cnt_val)
);

// File: tb/sim_adc_accum_mon.sv
module sim_adc_accum_mon;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        restart = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        out_valid;
    logic [15:0] out_data;
    logic        irq_count, irq_thresh, irq_ovr;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];

    // bench model of the requirements
    logic [4:0]  m_ctrl = '0;
    logic [15:0] m_limit = '0, m_thr = '0;
    logic [3:0]  m_st = '0;
    logic [31:0] m_acc = '0;
    logic [15:0] m_cnt = '0;
    int          m_seen = 0;

    always #10 clk = ~clk;

    adc_accum_mon u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected out_valid", {16'h0, out_data}, 32'hDEAD);
            end else begin
                chk("R3 out_data", {16'h0, out_data}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic tick(input logic v, input logic [15:0] d, input logic rs,
                        input logic wr, input logic [2:0] a, input logic [31:0] wd);
        logic        settled, clr;
        int          need, mag;
        logic [31:0] base, term, sum;
        logic [16:0] cn;
        logic [3:0]  set;
        @(negedge clk);
        res_valid = v; res_data = d; restart = rs;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        @(posedge clk);
        set  = '0;
        need = m_ctrl[4] ? 1 : 2;
        settled = v && !rs && (m_seen >= need);
        if (rs) m_seen = 0;
        else if (v && m_seen < need) m_seen++;
        clr = wr && a == 3'd3 && wd[0];
        if (v && m_ctrl[3] && (d == 16'h7FFF || d == 16'h8000)) set[2] = 1'b1;
        if (settled) exp_q.push_back(d);
        base = clr ? 32'h0 : m_acc;
        if (settled && m_ctrl[0]) begin
            term = {{16{d[15]}}, d};
            sum  = base + term;
            if (base[31] == term[31] && sum[31] != base[31]) set[3] = 1'b1;
            m_acc = sum;
        end else m_acc = base;
        if (clr) m_cnt = '0;
        if (settled && m_ctrl[1]) begin
            cn = {1'b0, m_cnt} + 17'd1;
            if (cn == {1'b0, m_limit}) begin set[0] = 1'b1; m_cnt = '0; end
            else m_cnt = cn[15:0];
        end
        mag = $signed(d);
        if (mag < 0) mag = -mag;
        if (settled && m_ctrl[2] && mag > int'(m_thr)) set[1] = 1'b1;
        m_st = (m_st & ~((wr && a == 3'd4) ? wd[3:0] : 4'h0)) | set;
        if (wr && a == 3'd0) m_ctrl = wd[4:0];
        if (wr && a == 3'd1) m_limit = wd[15:0];
        if (wr && a == 3'd2) m_thr = wd[15:0];
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] wd);
        tick(1'b0, 16'h0, 1'b0, 1'b1, a, wd);
    endtask
    task automatic send(input logic [15:0] d);
        tick(1'b1, d, 1'b0, 1'b0, 3'd0, 32'h0);
    endtask
    task automatic pulse_restart();
        tick(1'b0, 16'h0, 1'b1, 1'b0, 3'd0, 32'h0);
    endtask
    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        tick(1'b0, 16'h0, 1'b0, 1'b0, a, 32'h0);
        @(negedge clk);
        res_valid = 0; restart = 0; reg_wr = 0; reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 out_valid reset", {31'h0, out_valid}, 32'h0);
        chk("R1 irq reset", {29'h0, irq_count, irq_thresh, irq_ovr}, 32'h0);
        rd(3'd0, 32'h0, "R1 ctrl reset");
        rd(3'd4, 32'h0, "R1 status reset");
        rd(3'd5, 32'h0, "R1 acc reset");
        rd(3'd6, 32'h0, "R1 count reset");

        // chop off: two discards
        wreg(3'd2, 32'h1000);
        wreg(3'd1, 32'd3);
        wreg(3'd0, 32'h07);
        send(16'd100); send(16'd200); send(16'd300); send(-16'sd50); send(16'd1000);
        rd(3'd5, 32'd1250, "R2 R4 acc after chop-off discards");
        rd(3'd6, 32'd0, "R6 counter reload");
        rd(3'd4, 32'h1, "R6 count flag");
        chk("R10 irq_count", {31'h0, irq_count}, 32'h1);
        wreg(3'd4, 32'hF);
        rd(3'd4, 32'h0, "R10 w1c");
        send(16'd5);
        rd(3'd6, 32'd1, "R6 count one");

        // restart with a same-cycle result, then chop on: one discard
        tick(1'b1, 16'd77, 1'b1, 1'b0, 3'd0, 32'h0);
        wreg(3'd0, 32'h17);
        send(16'd7); send(16'd8);
        rd(3'd5, 32'd1263, "R2 acc after chop-on discard");

        // threshold boundary (counter also reaches 3 here)
        send(16'h1000);
        rd(3'd4, {28'h0, m_st}, "R7 equal magnitude");
        chk("R7 equal not flagged", {31'h0, irq_thresh}, 32'h0);
        send(16'hEFFF);
        rd(3'd4, {28'h0, m_st}, "R7 negative beyond threshold");
        chk("R7 irq_thresh", {31'h0, irq_thresh}, 32'h1);
        tick(1'b1, 16'hEFFF, 1'b0, 1'b1, 3'd4, 32'h2);
        rd(3'd4, {28'h0, m_st}, "R10 set wins over clear");
        wreg(3'd4, 32'hF);

        // overrange during settling
        wreg(3'd0, 32'h1F);
        pulse_restart();
        send(16'h7FFF);
        rd(3'd4, 32'h4, "R8 overrange while unsettled");
        chk("R8 irq_ovr", {31'h0, irq_ovr}, 32'h1);
        wreg(3'd4, 32'hF);
        wreg(3'd0, 32'h17);
        send(16'h8000);
        rd(3'd4, {28'h0, m_st}, "R11 overrange disabled");
        chk("R11 no irq_ovr", {31'h0, irq_ovr}, 32'h0);
        wreg(3'd4, 32'hF);

        // accumulation disabled
        wreg(3'd0, 32'h16);
        rd(3'd5, m_acc, "R11 acc before");
        send(16'd50);
        rd(3'd5, m_acc, "R11 acc unchanged");

        // clear with concurrent result
        wreg(3'd0, 32'h17);
        tick(1'b1, 16'd5, 1'b0, 1'b1, 3'd3, 32'h1);
        rd(3'd5, 32'd5, "R9 acc first new term");
        rd(3'd6, 32'd1, "R9 count first new term");

        // overflow burst
        wreg(3'd0, 32'h11);
        wreg(3'd3, 32'h1);
        wreg(3'd4, 32'hF);
        for (int i = 0; i < 65540; i++) send(16'h7FFE);
        rd(3'd4, 32'h0, "R5 no overflow before limit");
        send(16'h7FFE);
        rd(3'd4, 32'h8, "R5 overflow flag");
        rd(3'd5, 32'h80007FF6, "R5 wrapped acc");

        repeat (3) @(negedge clk);
        chk("R3 all results delivered", exp_q.size(), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule